// File: doc/BRIEF.md
# Search ROM Triplet Accelerator

This block sits inside a single-wire bus master and speeds up the ID search that finds every device on the bus. While accelerator mode is on, each byte the host writes carries four chosen-path bits. For each of those bits the block runs three bus slots: it reads the ID bit, reads its complement, then writes the direction bit. One result byte comes back per exchange, holding four resolved ID bits and four discrepancy flags. Sixteen exchanges cover a 64-bit ID, lowest nibble first.

Path and result bits are interleaved. ID and path bits sit at the odd positions and discrepancy flags at the even positions, lowest ID bit first. The master's existing slot generator drives the bus timing. This block requests one slot at a time and takes the sampled bit back when the slot completes. Choosing the next search path stays with the host.

Top module: `sra_triplet_accel`

## Requirements
- R1: While `acc_en` is low, a write on `wr_valid` requests no bus slot and produces no result (`rx_full` stays 0).
- R2: The path bit for ID bit k of the current nibble is taken from `wr_data` bit 2k+1 (k = 0..3). The even bits of `wr_data` have no effect on the slots or the result.
- R3: Each byte exchange runs exactly 12 slots: for ID bits k = 0,1,2,3 in that order, a read slot, a second read slot (complement), then a write slot.
- R4: If the two reads differ, the ID bit is the first read value and the discrepancy flag is 0. If both are 0, the flag is 1 and the ID bit is the path bit. If both are 1, both are 1.
- R5: The write slot of each bit drives `slot_wbit` equal to the resolved ID bit, and holds it steady while the request is active.
- R6: On completion, `rx_data` bit 2k+1 holds ID bit k and bit 2k holds discrepancy flag k. `rx_full` rises two clock edges after the final write slot's `slot_done` and holds `rx_data` unchanged until `rx_ack`, which clears it.
- R7: `bus_err` is set with `rx_full` on the 16th exchange since mode entry when that byte's bits 7 and 6 are both 1. It is 0 on every other exchange and is cleared by `rx_ack`.
- R8: Lowering `acc_en` restarts the exchange count, so the 16th exchange is counted from the latest mode entry.
- R9: A write that arrives while an exchange is running is ignored: the slot count and result of the running exchange are unchanged and no further exchange starts.
- R10: After reset, `rx_full`, `bus_err` and `slot_req` are 0.
- R11: A host search loop built on the exchanges recovers the ID of every device on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Accelerator mode enable from the command register |
| wr_valid | input | 1 | Host data-register write strobe |
| wr_data | input | 8 | Written byte; path bits at odd positions |
| rx_ack | input | 1 | Host read of the result, clears `rx_full` |
| rx_data | output | 8 | Result byte: ID bits odd, discrepancy flags even |
| rx_full | output | 1 | Receive-buffer-full event for the result |
| bus_err | output | 1 | Final exchange reported ID and discrepancy both set |
| slot_req | output | 1 | Request to the slot generator |
| slot_wr | output | 1 | Requested slot is a write (1) or read (0) |
| slot_wbit | output | 1 | Bit to drive in a write slot |
| slot_done | input | 1 | One-cycle pulse: requested slot finished |
| slot_rbit | input | 1 | Bus value sampled in a finished read slot |

## Verification
A result is due two clock edges after the `slot_done` that ends the twelfth slot of the exchange. How long that takes depends on the slot generator, so the bench never waits a fixed number of cycles. It polls `rx_full` on falling edges and counts the slots served since the write. A result is accepted only when exactly 12 slots have passed. Each direction bit is checked inside the slot model at the moment the write slot completes, against a value computed from the device set before the exchange began. Negative cases, such as writes outside the mode or during an exchange, are checked by watching the slot request and `rx_full` over a window of cycles longer than one slot.

// File: rtl/sra_pkg.sv
package sra_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_RD_TRUE = 3'd1,
    SQ_RD_CMP  = 3'd2,
    SQ_WR_DIR  = 3'd3,
    SQ_FIN     = 3'd4
  } seq_state_t;

  // Resolve one bit from the true read, the complement read and the path bit.
  // Returns {id_bit, disc_flag}.
  function automatic logic [1:0] resolve_bit(input logic rd_true,
                                             input logic rd_cmp,
                                             input logic path);
    logic [1:0] res;
    if (rd_true != rd_cmp)      res = {rd_true, 1'b0};
    else if (!rd_true)          res = {path, 1'b1};
    else                        res = 2'b11;
    return res;
  endfunction

endpackage

// File: rtl/sra_path_unpack.sv
module sra_path_unpack #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic [BYTE_W-1:0] byte_in,
  output logic [NIB_W-1:0]  path_out
);

  for (genvar k = 0; k < NIB_W; k++) begin : g_odd
    assign path_out[k] = byte_in[2*k+1];
  end

endmodule

// File: rtl/sra_triplet_seq.sv
module sra_triplet_seq
  import sra_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int IDX_W = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NIB_W-1:0] path_in,
  input  logic             slot_done,
  input  logic             slot_rbit,
  output logic             slot_req,
  output logic             slot_wr,
  output logic             slot_wbit,
  output logic             step_valid,
  output logic [IDX_W-1:0] step_idx,
  output logic             step_id,
  output logic             step_disc,
  output logic             byte_done,
  output logic             busy
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIB_W - 1);

  seq_state_t       st_q, st_d;
  logic [NIB_W-1:0] path_q, path_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             first_q, first_d;
  logic             id_q, id_d;
  logic             disc_q, disc_d;
  logic [1:0]       resolved;

  assign resolved = resolve_bit(first_q, slot_rbit, path_q[idx_q]);

  always_comb begin
    st_d    = st_q;
    path_d  = path_q;
    idx_d   = idx_q;
    first_d = first_q;
    id_d    = id_q;
    disc_d  = disc_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          path_d = path_in;
          idx_d  = '0;
          st_d   = SQ_RD_TRUE;
        end
      end
      SQ_RD_TRUE: begin
        if (slot_done) begin
          first_d = slot_rbit;
          st_d    = SQ_RD_CMP;
        end
      end
      SQ_RD_CMP: begin
        if (slot_done) begin
          id_d   = resolved[1];
          disc_d = resolved[0];
          st_d   = SQ_WR_DIR;
        end
      end
      SQ_WR_DIR: begin
        if (slot_done) begin
          if (idx_q == LAST_IDX) begin
            st_d = SQ_FIN;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = SQ_RD_TRUE;
          end
        end
      end
      SQ_FIN:  st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      path_q  <= '0;
      idx_q   <= '0;
      first_q <= 1'b0;
      id_q    <= 1'b0;
      disc_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      path_q  <= path_d;
      idx_q   <= idx_d;
      first_q <= first_d;
      id_q    <= id_d;
      disc_q  <= disc_d;
    end
  end

  assign slot_req   = (st_q == SQ_RD_TRUE) || (st_q == SQ_RD_CMP) || (st_q == SQ_WR_DIR);
  assign slot_wr    = (st_q == SQ_WR_DIR);
  assign slot_wbit  = (st_q == SQ_WR_DIR) ? id_q : 1'b0;
  assign step_valid = (st_q == SQ_WR_DIR) && slot_done;
  assign step_idx   = idx_q;
  assign step_id    = id_q;
  assign step_disc  = disc_q;
  assign byte_done  = (st_q == SQ_FIN);
  assign busy       = (st_q != SQ_IDLE);

endmodule

// File: rtl/sra_result_pack.sv
module sra_result_pack #(
  parameter int NIB_W = 4,
  parameter int ID_W  = 64,
  localparam int BYTE_W = 2 * NIB_W,
  localparam int EXCH   = ID_W / NIB_W,
  localparam int CNT_W  = (EXCH > 1) ? $clog2(EXCH) : 1,
  localparam int IDX_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              step_valid,
  input  logic [IDX_W-1:0]  step_idx,
  input  logic              step_id,
  input  logic              step_disc,
  input  logic              byte_done,
  input  logic              rx_ack,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full,
  output logic              bus_err
);

  localparam logic [CNT_W-1:0] LAST_EXCH = CNT_W'(EXCH - 1);

  logic [NIB_W-1:0]  id_acc_q, id_acc_d;
  logic [NIB_W-1:0]  disc_acc_q, disc_acc_d;
  logic [BYTE_W-1:0] packed_byte;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              full_q, full_d;
  logic              err_q, err_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;

  for (genvar k = 0; k < NIB_W; k++) begin : g_pack
    assign packed_byte[2*k]   = disc_acc_q[k];
    assign packed_byte[2*k+1] = id_acc_q[k];
  end

  always_comb begin
    id_acc_d   = id_acc_q;
    disc_acc_d = disc_acc_q;
    if (step_valid) begin
      id_acc_d[step_idx]   = step_id;
      disc_acc_d[step_idx] = step_disc;
    end
  end

  always_comb begin
    data_d = data_q;
    full_d = full_q;
    err_d  = err_q;
    if (byte_done) begin
      data_d = packed_byte;
      full_d = 1'b1;
      err_d  = (cnt_q == LAST_EXCH) && id_acc_q[NIB_W-1] && disc_acc_q[NIB_W-1];
    end else if (rx_ack) begin
      full_d = 1'b0;
      err_d  = 1'b0;
    end
  end

  assign cnt_en = byte_done || !acc_en;

  always_comb begin
    if (!acc_en)                 cnt_d = '0;
    else if (cnt_q == LAST_EXCH) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_acc_q   <= '0;
      disc_acc_q <= '0;
    end else if (step_valid) begin
      id_acc_q   <= id_acc_d;
      disc_acc_q <= disc_acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign rx_data = data_q;
  assign rx_full = full_q;
  assign bus_err = err_q;

endmodule

// File: rtl/sra_triplet_accel.sv
module sra_triplet_accel #(
  parameter int NIB_W = 4,
  parameter int ID_W  = 64,
  localparam int BYTE_W = 2 * NIB_W,
  localparam int IDX_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rx_ack,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full,
  output logic              bus_err,
  output logic              slot_req,
  output logic              slot_wr,
  output logic              slot_wbit,
  input  logic              slot_done,
  input  logic              slot_rbit
);

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic [NIB_W-1:0] path_bits;
  logic             seq_busy;
  logic             seq_start;
  logic             step_valid;
  logic [IDX_W-1:0] step_idx;
  logic             step_id;
  logic             step_disc;
  logic             byte_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign seq_start = acc_en && wr_valid && !seq_busy;

  sra_path_unpack #(.NIB_W(NIB_W)) u_unpack (
    .byte_in  (wr_data),
    .path_out (path_bits)
  );

  sra_triplet_seq #(.NIB_W(NIB_W)) u_seq (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .start      (seq_start),
    .path_in    (path_bits),
    .slot_done  (slot_done),
    .slot_rbit  (slot_rbit),
    .slot_req   (slot_req),
    .slot_wr    (slot_wr),
    .slot_wbit  (slot_wbit),
    .step_valid (step_valid),
    .step_idx   (step_idx),
    .step_id    (step_id),
    .step_disc  (step_disc),
    .byte_done  (byte_done),
    .busy       (seq_busy)
  );

  sra_result_pack #(.NIB_W(NIB_W), .ID_W(ID_W)) u_pack (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .acc_en     (acc_en),
    .step_valid (step_valid),
    .step_idx   (step_idx),
    .step_id    (step_id),
    .step_disc  (step_disc),
    .byte_done  (byte_done),
    .rx_ack     (rx_ack),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .bus_err    (bus_err)
  );

endmodule

// File: rtl/sra_triplet_checker.sv
module sra_triplet_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              seq_busy,
  input logic              slot_req,
  input logic              slot_wr,
  input logic              slot_wbit,
  input logic              slot_done,
  input logic              rx_full,
  input logic [BYTE_W-1:0] rx_data,
  input logic              bus_err
);

  AST_NO_SLOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !seq_busy) |-> !slot_req) else $error("no slot outside mode"); // R1

  AST_DIR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_req && slot_wr) |-> $past(slot_done && !slot_wr)) else $error("write slot follows a read"); // R3

  AST_DIR_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && slot_wr && $past(slot_req && slot_wr && !slot_done)) |-> $stable(slot_wbit)) else $error("direction bit moved"); // R5

  AST_RX_AFTER_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(slot_done && slot_wr, 2)) else $error("result not after write slot"); // R6

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && $past(rx_full)) |-> $stable(rx_data)) else $error("result changed while full"); // R6

  AST_ERR_WITH_RX: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> rx_full) else $error("bus error without result"); // R7

endmodule

bind sra_triplet_accel sra_triplet_checker #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sim_sra_triplet_accel.sv
module sim_sra_triplet_accel;

  localparam int NDEV = 3;
  localparam int SLOT_LEN = 3;

  logic       clk;
  logic       rst_n;
  logic       acc_en;
  logic       wr_valid;
  logic [7:0] wr_data;
  logic       rx_ack;
  logic [7:0] rx_data;
  logic       rx_full;
  logic       bus_err;
  logic       slot_req;
  logic       slot_wr;
  logic       slot_wbit;
  logic       slot_done;
  logic       slot_rbit;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  sra_triplet_accel u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .rx_ack(rx_ack), .rx_data(rx_data), .rx_full(rx_full),
    .bus_err(bus_err), .slot_req(slot_req), .slot_wr(slot_wr),
    .slot_wbit(slot_wbit), .slot_done(slot_done), .slot_rbit(slot_rbit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Device set
  logic [63:0] dev_id [NDEV];
  logic [NDEV-1:0] present;
  logic [NDEV-1:0] live;       // slot model view
  logic [NDEV-1:0] exp_live;   // expectation view
  int   m_bitpos;
  int   e_bitpos;
  bit   m_phase;
  logic exp_dir [64];
  int   slot_cnt;

  // Slot generator and device model
  bit   m_busy;
  int   m_cnt;
  bit   m_wr;
  logic m_wb;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy    = 0;
      slot_done <= 1'b0;
      slot_rbit <= 1'b0;
    end else if (slot_done) begin
      slot_done <= 1'b0;
    end else if (m_busy) begin
      if (m_cnt == 0) begin
        m_busy = 0;
        slot_cnt++;
        if (m_wr) begin
          nchk++;
          if (m_bitpos < 64 && m_wb !== exp_dir[m_bitpos]) begin
            nerr++;
            $display("FAIL R5 direction bit %0d: got %b expected %b", m_bitpos, m_wb, exp_dir[m_bitpos]);
          end
          for (int d = 0; d < NDEV; d++)
            if (live[d] && m_bitpos < 64 && dev_id[d][m_bitpos] != m_wb) live[d] = 1'b0;
          m_bitpos++;
          m_phase = 0;
          slot_rbit <= 1'b1;
        end else begin
          logic v;
          v = 1'b1;
          for (int d = 0; d < NDEV; d++)
            if (live[d] && m_bitpos < 64)
              v = v & (m_phase ? ~dev_id[d][m_bitpos] : dev_id[d][m_bitpos]);
          slot_rbit <= v;
          m_phase = ~m_phase;
        end
        slot_done <= 1'b1;
      end else begin
        m_cnt--;
      end
    end else if (slot_req) begin
      m_busy = 1;
      m_cnt  = SLOT_LEN;
      m_wr   = slot_wr;
      m_wb   = slot_wbit;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic start_pass();
    @(negedge clk);
    acc_en = 1'b0;
    @(negedge clk);
    live     = present;
    exp_live = present;
    m_bitpos = 0;
    e_bitpos = 0;
    m_phase  = 0;
    acc_en   = 1'b1;
  endtask

  // Expected result byte, computed from the resolution rules
  task automatic expect_byte(input [3:0] path, output [7:0] res);
    res = 8'h00;
    for (int k = 0; k < 4; k++) begin
      bit any0, any1, a, b, idb, dsc;
      int p;
      p = e_bitpos + k;
      any0 = 0; any1 = 0;
      for (int d = 0; d < NDEV; d++)
        if (exp_live[d]) begin
          if (dev_id[d][p]) any1 = 1; else any0 = 1;
        end
      a = !any0;
      b = !any1;
      if (a != b)  begin idb = a;       dsc = 0; end
      else if (!a) begin idb = path[k]; dsc = 1; end
      else         begin idb = 1;       dsc = 1; end
      exp_dir[p] = idb;
      for (int d = 0; d < NDEV; d++)
        if (exp_live[d] && dev_id[d][p] != idb) exp_live[d] = 1'b0;
      res[2*k+1] = idb;
      res[2*k]   = dsc;
    end
    e_bitpos += 4;
  endtask

  task automatic exchange(input [3:0] path, input [3:0] noise, input int exch_no,
                          output [7:0] got);
    logic [7:0] wbyte, exp;
    bit experr;
    int guard;
    for (int k = 0; k < 4; k++) begin
      wbyte[2*k+1] = path[k];
      wbyte[2*k]   = noise[k];
    end
    expect_byte(path, exp);
    experr = (exch_no == 15) && exp[7] && exp[6];
    slot_cnt = 0;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = wbyte;
    @(negedge clk);
    wr_valid = 1'b0;
    guard = 0;
    while (!rx_full && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    got = rx_data;
    chk(rx_data == exp, "R4 R6 result byte", rx_data, exp);   // R2 even bits ignored too
    chk(slot_cnt == 12, "R3 slots per exchange", slot_cnt, 12);
    chk(bus_err == experr, "R7 bus error flag", bus_err, experr);
    repeat (3) @(negedge clk);
    chk(rx_full == 1'b1 && rx_data == exp, "R6 result held", rx_data, exp);
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
    chk(rx_full == 1'b0 && bus_err == 1'b0, "R6 R7 cleared by ack", {rx_full, bus_err}, 0);
  endtask

  task automatic run_pass(input [63:0] r, output [63:0] idv, output [63:0] dv);
    logic [7:0] b;
    start_pass();
    idv = '0; dv = '0;
    for (int i = 0; i < 16; i++) begin
      exchange(r[4*i +: 4], 4'(i * 5 + 3), i, b);
      for (int k = 0; k < 4; k++) begin
        idv[4*i+k] = b[2*k+1];
        dv[4*i+k]  = b[2*k];
      end
    end
  endtask

  initial begin
    logic [63:0] r, idv, dv, found [8];
    logic [7:0]  b;
    int nfound, m, quiet;
    dev_id[0] = 64'hA5A5_0000_1234_5678;
    dev_id[1] = 64'hA5A5_0000_1234_5679;
    dev_id[2] = 64'h3C00_FFFF_0000_0778;
    present  = '1;
    live     = '0;
    exp_live = '0;
    m_bitpos = 0;
    e_bitpos = 0;
    m_phase  = 0;
    slot_cnt = 0;
    rst_n = 1'b0; acc_en = 1'b0; wr_valid = 1'b0; wr_data = 8'h00; rx_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rx_full == 0 && bus_err == 0 && slot_req == 0, "R10 reset state", {rx_full, bus_err, slot_req}, 0);

    // R1: write outside the mode
    slot_cnt = 0; quiet = 1;
    wr_valid = 1'b1; wr_data = 8'hAA;
    @(negedge clk);
    wr_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (slot_req || rx_full) quiet = 0;
    end
    chk(quiet == 1 && slot_cnt == 0, "R1 no activity outside mode", slot_cnt, 0);

    // R11 with R2/R4/R5: full search over three devices
    r = '0; nfound = 0;
    for (int pass = 0; pass < 8; pass++) begin
      run_pass(r, idv, dv);
      chk(!(idv[63] && dv[63]), "R11 no bus error with devices", dv[63], 0);
      found[nfound] = idv; nfound++;
      dv = dv & ~r;
      if (dv == '0) break;
      m = 63;
      while (!dv[m]) m--;
      r = (r & ((64'd1 << m) - 64'd1)) | (64'd1 << m);
    end
    chk(nfound == NDEV, "R11 device count", nfound, NDEV);
    for (int d = 0; d < NDEV; d++) begin
      bit hit; hit = 0;
      for (int f = 0; f < nfound; f++) if (found[f] == dev_id[d]) hit = 1;
      chk(hit, "R11 device found", d, d);
    end

    // R2: even bits swept on one nibble, odd bits fixed
    for (int n = 0; n < 16; n++) begin
      start_pass();
      exchange(4'b0110, 4'(n), 0, b);
    end

    // R9: second write during an exchange
    start_pass();
    begin
      logic [7:0] exp;
      expect_byte(4'b1010, exp);
      slot_cnt = 0;
      @(negedge clk); wr_valid = 1'b1; wr_data = 8'b1000_1000;
      @(negedge clk); wr_valid = 1'b0;
      repeat (6) @(negedge clk);
      wr_valid = 1'b1; wr_data = 8'b0111_0111;
      @(negedge clk); wr_valid = 1'b0;
      while (!rx_full) @(negedge clk);
      chk(rx_data == exp, "R9 result of first write", rx_data, exp);
      chk(slot_cnt == 12, "R9 slot count", slot_cnt, 12);
      rx_ack = 1'b1; @(negedge clk); rx_ack = 1'b0;
      quiet = 1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (slot_req || rx_full) quiet = 0;
      end
      chk(quiet == 1, "R9 no extra exchange", quiet, 1);
    end

    // R7/R8: empty bus, count restarts on mode exit
    present = '0;
    start_pass();
    for (int i = 0; i < 8; i++) exchange(4'h0, 4'h0, i, b);
    start_pass();
    for (int i = 0; i < 16; i++) begin
      exchange(4'h0, 4'hF, i, b);
      chk(b == 8'hFF, "R8 empty bus byte", b, 8'hFF);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule